// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a small self-compacting queue of `DEPTH` words, each `WIDTH` bits wide. Every slot has its own valid marker. A filled slot hands its word to the next slot toward the output as soon as that slot is empty. Each step takes one clock, so free slots gather at the input end and stored words collect at the output end. There are no read or write pointers. The two handshake flags are simply the markers of the two end slots.

A producer loads a word by raising `shift_in` while `in_ready` is high. A consumer removes the word shown on `dout` by dropping `shift_out` while `out_ready` is high. Both strobes are treated as asynchronous levels. They pass through two synchronising flops on `clk`, and edges are found by comparing successive samples. While `out_disable` is high, unloading is blocked. A master reset drops every marker but leaves the stored words as they are. Because the flags are levels taken straight from the end slots, two instances can be chained: the upstream `out_ready` drives the downstream `shift_in`, and the downstream `in_ready` drives the upstream `shift_out`.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `in_ready` is 1 and `out_ready` is 0.
- R2: A word on `din` is accepted into the input slot on the third rising `clk` edge after `shift_in` goes from 0 to 1, provided `in_ready` is high at that point. `in_ready` then stays low for exactly one cycle while the word moves on, as long as the queue is not full.
- R3: Holding `shift_in` high loads only one word. Another word is accepted only after `shift_in` has returned to 0 and risen again.
- R4: A word moves one slot per clock. For the default `DEPTH` of 16, `out_ready` rises 15 cycles after `in_ready` fell for a word written into an empty queue.
- R5: Words leave in the order they were written, and `dout` shows the oldest word whenever `out_ready` is 1.
- R6: When all `DEPTH` slots are valid, `in_ready` is 0 and rising edges on `shift_in` do not add a word.
- R7: A 1-to-0 transition of `shift_out` while `out_ready` is high and `out_disable` is low clears the output slot on the third clock edge after the transition. `out_ready` is then 0 for one cycle, and `dout` shows the next word if one was queued behind it.
- R8: When the queue is empty, `shift_out` edges are ignored, and `out_ready` stays 0 until a valid word reaches the output slot.
- R9: While `out_disable` is 1, falling edges of `shift_out` remove nothing: `out_ready` stays 1 and `dout` holds its value.
- R10: Reset invalidates all stored words without clearing them. After reset, only words written after reset are read out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, clears all markers |
| shift_in | input | 1 | Load strobe; a rising edge writes `din` |
| din | input | WIDTH | Word to load |
| in_ready | output | 1 | High when the input slot is free |
| shift_out | input | 1 | Unload strobe; a falling edge removes the output word |
| out_disable | input | 1 | High blocks unloading |
| dout | output | WIDTH | Word held in the output slot |
| out_ready | output | 1 | High when the output slot holds a valid word |

## Verification
The bench builds the block with its default values, `DEPTH` of 16 and `WIDTH` of 4. At that depth the full 15-cycle ripple latency can be timed exactly. The same size makes the full condition reachable with sixteen writes, so the ignored seventeenth write can be observed by draining the queue. A four-bit word also lets every stored value in a full queue be distinct, which exposes any reordering or duplication during the drain.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  input  logic             out_disable,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready
);
  localparam int LAST = DEPTH - 1;

  logic [2:0]       si_q, so_q;
  logic [DEPTH-1:0] valid_q, valid_d, move, take;
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic             push, pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_q <= '0;
      so_q <= '0;
    end else begin
      si_q <= {si_q[1:0], shift_in};
      so_q <= {so_q[1:0], shift_out};
    end
  end

  assign push = si_q[1] & ~si_q[2] & ~valid_q[0];
  assign pop  = ~so_q[1] & so_q[2] & valid_q[LAST] & ~out_disable;

  always_comb begin
    move[0]    = push;
    take[LAST] = pop;
    for (int i = 1; i < DEPTH; i++) move[i] = valid_q[i-1] & ~valid_q[i];
    for (int i = 0; i < LAST; i++) take[i] = move[i+1];
    for (int i = 0; i < DEPTH; i++) valid_d[i] = valid_q[i] ? ~take[i] : move[i];
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  always_ff @(posedge clk)
    if (move[0]) slot_q[0] <= din;

  for (genvar g = 1; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk)
      if (move[g]) slot_q[g] <= slot_q[g-1];

    assert_ripple_R4: assert property (@(posedge clk) disable iff (rst)
      valid_q[g-1] && !valid_q[g] |=> valid_q[g] && slot_q[g] == $past(slot_q[g-1]));
  end

  assign in_ready  = ~valid_q[0];
  assign out_ready = valid_q[LAST];
  assign dout      = slot_q[LAST];

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> in_ready && !out_ready);

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (&valid_q) && !pop |=> !in_ready);

  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    pop |=> !out_ready);

  assert_empty_stays_R8: assert property (@(posedge clk) disable iff (rst)
    !out_ready && !valid_q[LAST-1] |=> !out_ready);

  assert_disable_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    out_disable && out_ready |=> out_ready && $stable(dout));
endmodule

// File: tb/sim_bubble_fifo.sv
module sim_bubble_fifo;
  logic       clk = 0, rst = 1, shift_in = 0, shift_out = 0, out_disable = 0;
  logic [3:0] din = '0, dout;
  logic       in_ready, out_ready;
  int         errors = 0, checks = 0;

  always #4 clk = ~clk;

  bubble_fifo #(.DEPTH(16), .WIDTH(4)) u0 (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .in_ready(in_ready),
    .shift_out(shift_out), .out_disable(out_disable), .dout(dout), .out_ready(out_ready));

  // bit 4: 1 = pop and compare, 0 = push; bits 3:0: word
  localparam logic [4:0] VEC [0:11] = '{
    5'h03, 5'h0A, 5'h05, 5'h13, 5'h0C, 5'h1A,
    5'h15, 5'h0F, 5'h00, 5'h1C, 5'h1F, 5'h10};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(logic [3:0] d);
    din = d; shift_in = 1; cyc(4);
    shift_in = 0; cyc(4);
  endtask

  task automatic pulse_out();
    shift_out = 1; cyc(4);
    shift_out = 0; cyc(4);
  endtask

  task automatic pop_word(string req, logic [3:0] exp);
    for (int k = 0; k < 40 && !out_ready; k++) cyc(1);
    chk(req, out_ready, 1);
    chk(req, dout, exp);
    pulse_out();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cyc(100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 in_ready in reset", in_ready, 1);
    chk("R1 out_ready in reset", out_ready, 0);
    rst = 0; cyc(1);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 out_ready after reset", out_ready, 0);

    // R2 / R4 exact timing
    din = 4'h6; shift_in = 1; cyc(2);
    chk("R2 not yet accepted", in_ready, 1);
    cyc(1);
    chk("R2 in_ready low after accept", in_ready, 0);
    cyc(1);
    chk("R2 in_ready back high", in_ready, 1);
    cyc(13);
    chk("R4 not arrived at 14", out_ready, 0);
    cyc(1);
    chk("R4 arrived at 15", out_ready, 1);
    chk("R4 word", dout, 4'h6);
    // R3: shift_in still high since above
    cyc(30); shift_in = 0; cyc(4);
    pulse_out(); cyc(1);
    cyc(30);
    chk("R3 single word from held strobe", out_ready, 0);

    // R5 vector table
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][4]) pop_word("R5 order", VEC[v][3:0]);
      else push_word(VEC[v][3:0]);
    end
    cyc(30);
    chk("R5 drained", out_ready, 0);

    // R7 exact pop timing with a word behind
    push_word(4'h1); push_word(4'h2); cyc(30);
    shift_out = 1; cyc(4); shift_out = 0; cyc(2);
    chk("R7 still valid before third edge", out_ready, 1);
    cyc(1);
    chk("R7 out_ready low one cycle", out_ready, 0);
    cyc(1);
    chk("R7 next word ready", out_ready, 1);
    chk("R7 next word value", dout, 4'h2);
    cyc(4);
    pop_word("R7 last", 4'h2);
    cyc(30);

    // R6 full
    for (int i = 0; i < 16; i++) push_word(4'(i ^ 9));
    cyc(30);
    chk("R6 in_ready low when full", in_ready, 0);
    chk("R6 out_ready when full", out_ready, 1);
    push_word(4'h7);

    // R9 disable blocks unloading
    out_disable = 1;
    pulse_out(); cyc(10);
    chk("R9 out_ready kept", out_ready, 1);
    chk("R9 dout kept", dout, 4'h9);
    out_disable = 0; cyc(2);

    for (int i = 0; i < 16; i++) pop_word("R6 drain order", 4'(i ^ 9));
    cyc(30);
    chk("R6 extra write ignored", out_ready, 0);

    // R8 empty pops ignored
    pulse_out(); pulse_out(); cyc(5);
    chk("R8 out_ready stays low", out_ready, 0);
    push_word(4'hB); cyc(30);
    chk("R8 word after empty pops", dout, 4'hB);
    chk("R8 out_ready after word", out_ready, 1);
    pop_word("R8 pop", 4'hB);
    cyc(30);

    // R10 reset invalidates stored words
    push_word(4'hD); push_word(4'hE); cyc(30);
    rst = 1; cyc(2); rst = 0; cyc(1);
    chk("R10 out_ready after reset", out_ready, 0);
    chk("R10 in_ready after reset", in_ready, 1);
    push_word(4'h2); cyc(30);
    chk("R10 only new word", dout, 4'h2);
    pop_word("R10 pop", 4'h2);
    cyc(30);
    chk("R10 nothing stale", out_ready, 0);

    finish_run();
  end
endmodule